// File: doc/BRIEF.md
# Post-Reset Power-Down Watchdog Counter

This block is a safety timer that starts counting on its own as soon as reset is released. It needs no software action to start. If software does not turn it off before a fixed interval has passed, the block drives an active-low watchdog output low. A board can use that output to power-cycle or reset a system whose cores hung right after boot, at a time when the main service watchdog is not yet running.

Software turns the timer off by writing a 0 into bit 0 of a small control register. It writes through a one-cycle strobe with a 16-bit data word. The disable is one-way: once the bit is 0, no write can set it again, and only a new reset re-arms the timer. After the timer expires, the watchdog output stays low until reset. A read-back word and an expired flag let software see the current state.

The interval is fixed in hardware. It is the counter-clock frequency times a number of seconds, both set by parameters. The defaults are 32768 Hz and 16 s, which give 524288 counter cycles.

Top module: `pdg_guard`

## Requirements
- R1: While reset is low and just after it is released, `ctl_rd_o` reads 16'h0001 (enable set), `expired_o` is 0 and `wdog_no` is 1.
- R2: With the enable bit left at 1, `expired_o` becomes 1 and `wdog_no` becomes 0 at the TICKS-th rising clock edge after reset release, where TICKS = CLK_HZ * TIMEOUT_S, and not at any earlier edge.
- R3: A strobed write whose data bit 0 is 0 clears the enable bit at that clock edge. After that, strobed writes with bit 0 = 1 leave it at 0 until the next reset.
- R4: If the enable bit is cleared at edge TICKS-1 or earlier, `expired_o` stays 0 and `wdog_no` stays 1 for as long as reset is not applied.
- R5: Once expired, `expired_o` stays 1 and `wdog_no` stays 0 until reset, even if the enable bit is cleared afterwards.
- R6: A clearing write that lands on the TICKS-th edge itself does not prevent expiry at that edge.
- R7: Only bit 0 of the write data has an effect. A strobed write of 16'hFFFF leaves an enabled counter enabled, and a write of 16'hFFFE clears it. Bits 15..1 of `ctl_rd_o` always read 0.
- R8: Asserting reset after an expiry or a disable restores the R1 state and re-arms the counter, which then runs a full TICKS interval again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_stb_i | input | 1 | One-cycle write strobe for the control register |
| wr_data_i | input | 16 | Write data; bit 0 is the enable bit |
| ctl_rd_o | output | 16 | Control register read-back; bit 0 is enable, the rest are 0 |
| expired_o | output | 1 | Latched timeout status |
| wdog_no | output | 1 | Active-low watchdog output |

## Verification
The assertions take it that the write strobe and data are stable around the rising clock edge and change only between edges. They also take it that reset is the only way the enable bit can return to 1. The bench drives every input on the falling edge and applies reset only between scenarios. Each scenario places its clearing write at a chosen edge number relative to reset release, including the TICKS-1 and TICKS boundaries. A reduced TICKS value keeps each interval short.

// File: rtl/pdg_pkg.sv
package pdg_pkg;
    localparam int unsigned WORD_W  = 16;
    localparam int unsigned EN_BIT  = 0;
endpackage

// File: rtl/pdg_enable_reg.sv
module pdg_enable_reg
    import pdg_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_stb_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic              en_o,
    output logic [WORD_W-1:0] rd_o
);
    typedef struct packed {
        logic en;
    } en_state_t;

    en_state_t st_d, st_q;

    logic unused_hi_bits;
    assign unused_hi_bits = ^wr_data_i;

    always_comb begin
        st_d = st_q;
        // one-way: a write can only take the bit from 1 to 0
        if (wr_stb_i && !wr_data_i[EN_BIT]) begin
            st_d.en = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{en: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_o         = '0;
        rd_o[EN_BIT] = st_q.en;
    end
    assign en_o = st_q.en;

    assert_disable_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_o |=> !en_o);
    assert_clear_takes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_stb_i && !wr_data_i[EN_BIT]) |=> !en_o);
    assert_set_write_noop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_o && wr_stb_i && wr_data_i[EN_BIT]) |=> en_o);
endmodule

// File: rtl/pdg_timer.sv
module pdg_timer #(
    parameter int unsigned TICKS = 524288
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic arm_i,
    output logic expired_o
);
    localparam int unsigned CW = (TICKS > 2) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          exp;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (arm_i && !st_q.exp) begin
            if (st_q.cnt == LAST) begin
                st_d.exp = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{cnt: '0, exp: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign expired_o = st_q.exp;

    assert_cnt_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= LAST);
    assert_hold_when_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !arm_i |=> $stable(st_q.cnt));
    assert_no_fire_when_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!arm_i && !expired_o) |=> !expired_o);
    assert_expiry_latched_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expired_o |=> expired_o);
endmodule

// File: rtl/pdg_guard.sv
module pdg_guard
    import pdg_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 32768,
    parameter int unsigned TIMEOUT_S = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_stb_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic [WORD_W-1:0] ctl_rd_o,
    output logic              expired_o,
    output logic              wdog_no
);
    localparam int unsigned TICKS = CLK_HZ * TIMEOUT_S;

    logic en_w;
    logic exp_w;

    pdg_enable_reg u_en (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_stb_i (wr_stb_i),
        .wr_data_i(wr_data_i),
        .en_o     (en_w),
        .rd_o     (ctl_rd_o)
    );

    pdg_timer #(.TICKS(TICKS)) u_tmr (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .arm_i    (en_w),
        .expired_o(exp_w)
    );

    assign expired_o = exp_w;
    assign wdog_no   = ~exp_w;

    assert_readback_hi_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctl_rd_o[WORD_W-1:1] == '0);
endmodule

// File: tb/pdg_guard_tb_top.sv
module pdg_guard_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int unsigned HZ = 8;
    localparam int unsigned SEC = 4;
    localparam int unsigned TICKS = HZ * SEC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stb = 1'b0;
    logic [15:0] wdat = '0;
    logic [15:0] rd;
    logic        expd;
    logic        wdn;

    int checks = 0;
    int bad = 0;
    string phase = "R1";

    // behavioural reference
    int m_edges;
    bit m_en;
    bit m_exp;

    pdg_guard #(.CLK_HZ(HZ), .TIMEOUT_S(SEC)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wr_stb_i(stb), .wr_data_i(wdat),
        .ctl_rd_o(rd), .expired_o(expd), .wdog_no(wdn)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_edges = 0; m_en = 1; m_exp = 0;
        end else begin
            bit old_en;
            old_en = m_en;
            m_edges++;
            if (stb && (wdat[0] == 1'b0)) m_en = 0;
            if (old_en && !m_exp && m_edges >= TICKS) m_exp = 1;
            // counter stops while disabled, so elapsed enabled edges matter
            if (!old_en && !m_exp) m_edges--;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(phase, "model rd", rd, {15'b0, m_en});
            chk(phase, "model expired", expd, m_exp);
            chk(phase, "model wdog_n", wdn, !m_exp);
        end
    end

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        stb = 1'b0;
        wdat = '0;
        #(CLK_PERIOD/4);
        chk("R1", "rd in reset", rd, 16'h0001);
        chk("R1", "expired in reset", expd, 0);
        chk("R1", "wdog_n in reset", wdn, 1);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // write landing on the next rising edge
    task automatic wr(logic [15:0] d);
        stb = 1'b1; wdat = d;
        tick();
        stb = 1'b0; wdat = '0;
    endtask

    initial begin
        tick(2);
        do_reset();
        chk("R1", "rd after release", rd, 16'h0001);

        // R2: runs out with no software action
        phase = "R2";
        tick(TICKS - 1);
        chk("R2", "expired at edge TICKS-1", expd, 0);
        chk("R2", "wdog_n at edge TICKS-1", wdn, 1);
        tick();
        chk("R2", "expired at edge TICKS", expd, 1);
        chk("R2", "wdog_n at edge TICKS", wdn, 0);

        // R5: clear after expiry does not release
        phase = "R5";
        wr(16'h0000);
        chk("R5", "enable cleared", rd, 0);
        tick(5);
        chk("R5", "wdog_n latched", wdn, 0);

        // R8 / R7 / R3 / R4
        do_reset();
        phase = "R8";
        chk("R8", "rearmed rd", rd, 16'h0001);
        chk("R8", "rearmed wdog_n", wdn, 1);
        tick(5);
        phase = "R7";
        wr(16'hFFFF);
        chk("R7", "FFFF keeps enable", rd, 16'h0001);
        wr(16'hFFFE);
        chk("R7", "FFFE clears enable", rd, 16'h0000);
        phase = "R3";
        wr(16'h0001);
        chk("R3", "set ignored", rd, 16'h0000);
        wr(16'hFFFF);
        chk("R3", "set ignored again", rd, 16'h0000);
        phase = "R4";
        tick(3 * TICKS);
        chk("R4", "no expiry after disable", expd, 0);
        chk("R4", "wdog_n high after disable", wdn, 1);

        // R4 boundary: clear lands on edge TICKS-1
        do_reset();
        phase = "R4";
        tick(TICKS - 2);
        wr(16'h0000);
        tick(TICKS);
        chk("R4", "clear at TICKS-1 prevents", expd, 0);

        // R6: clear lands on edge TICKS
        do_reset();
        phase = "R6";
        tick(TICKS - 1);
        wr(16'h0000);
        chk("R6", "expired despite same-edge clear", expd, 1);
        chk("R6", "wdog_n low despite same-edge clear", wdn, 0);
        chk("R6", "enable cleared", rd, 0);

        // R8: full interval again after reset
        do_reset();
        phase = "R8";
        tick(TICKS - 1);
        chk("R8", "no early expiry after rearm", expd, 0);
        tick();
        chk("R8", "expiry after rearm", expd, 1);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule